// File: doc/BRIEF.md
# Bit-Serial Ternary Match Array with Per-Word Sleep

This block keeps a set of stored words and searches all of them against one key at a time. Each word holds ternary symbols: zero, one, or don't-care. The key arrives one bit per clock, least significant bit first, and every word checks its symbol for that bit position in the same cycle. Each word keeps a running match flag. A word that sees its first mismatching bit clears that flag and goes to sleep. A sleeping word stops evaluating its comparator until the next key begins. Power switching is not modelled here: sleep only gates the comparison enable.

Words are loaded beforehand through a write port. The port carries two rails per symbol position, a "one" rail and a "zero" rail. A pulse on the start input resets every word to the matching, awake state and begins a new key. A one-cycle done flag marks the end of the key. The match vector then holds the search result. A combinational count of the words still awake is available in every cycle. Width and depth are parameters, for example 3 x 9 or 144 x 256. A parameter also chooses whether the sleep flag is a register of its own or is derived from the match flag.

Top module: `serial_tcam`

## Requirements
- R1: Symbol encoding uses the pair (one rail, zero rail). (1,0) stores a one and (0,1) stores a zero. (0,0) stores don't-care, which never mismatches. (1,1) mismatches on every key bit. A word matches a key exactly when no position mismatches.
- R2: After reset every stored symbol is don't-care. `match_vec` is all ones, `awake_cnt` equals DEPTH and `srch_done` is low.
- R3: In the cycle after `srch_start` is sampled high, `match_vec` is all ones and `awake_cnt` equals DEPTH. This holds even when a previous key is still in progress.
- R4: The key bit for position j is sampled on the (j+1)-th rising edge after the start edge. In the cycle after that edge, `match_vec` reflects key positions 0..j.
- R5: Once a word's match bit has cleared, it stays cleared until the next `srch_start`.
- R6: A word that has mismatched sleeps and no longer compares. `awake_cnt` equals the number of set bits in `match_vec`, and it never rises during a key.
- R7: `srch_done` is high for exactly one cycle: the cycle after the edge that samples key position WIDTH-1.
- R8: The array ignores a write that arrives while a key is in progress. The array accepts writes only when it is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one stored word |
| wr_addr | input | AW | Index of the word to write |
| wr_one | input | WIDTH | "One" rail per symbol position |
| wr_zero | input | WIDTH | "Zero" rail per symbol position |
| srch_start | input | 1 | Begins a new key and initialises all words |
| key_bit | input | 1 | Current key bit, one position per cycle |
| match_vec | output | DEPTH | Per-word running match flag |
| srch_done | output | 1 | One-cycle flag after the last key position |
| awake_cnt | output | CW | Number of words not asleep |

## Verification
The initialised match vector is due one cycle after the start edge. The result of key position j is due one cycle after the (j+1)-th edge that follows. The done flag is due one cycle after the final position edge, and the awake count follows the sleep registers with no extra delay. The bench drives inputs on falling edges and samples each result on the falling edge that follows the edge producing it. A scoreboard holds the expected final vector and count for each full key and compares them when done is seen. The search task checks every position result in its own cycle, and checks that done drops again one cycle later.

// File: rtl/serial_tcam_pkg.sv
package serial_tcam_pkg;

   // Index width that stays at least one bit wide for degenerate sizes.
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // One symbol position against one key bit: the "one" rail fails on a zero
   // key bit, the "zero" rail fails on a one key bit.
   function automatic logic sym_miss(input logic one_r, input logic zero_r, input logic kb);
      return (one_r & ~kb) | (zero_r & kb);
   endfunction

endpackage

// File: rtl/serial_tcam_seq.sv
module serial_tcam_seq #(
   parameter int WIDTH = 16,
   parameter int SW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   output logic [SW-1:0] slice,
   output logic          done
);

   logic          busy_q;
   logic          done_q;
   logic [SW-1:0] slice_q;
   logic          last;

   assign last = (slice_q == SW'(WIDTH - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         slice_q <= '0;
      end else if (start) begin
         busy_q  <= 1'b1;
         done_q  <= 1'b0;
         slice_q <= '0;
      end else if (busy_q) begin
         if (last) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            slice_q <= '0;
         end else begin
            done_q  <= 1'b0;
            slice_q <= slice_q + 1'b1;
         end
      end else begin
         done_q <= 1'b0;
      end
   end

   assign busy  = busy_q;
   assign slice = slice_q;
   assign done  = done_q;

endmodule

// File: rtl/serial_tcam_word.sv
module serial_tcam_word import serial_tcam_pkg::*; #(
   parameter int WIDTH     = 16,
   parameter int SW        = 4,
   parameter bit SLEEP_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_sel,
   input  logic [WIDTH-1:0] wr_one,
   input  logic [WIDTH-1:0] wr_zero,
   input  logic             init,
   input  logic             cmp_en,
   input  logic [SW-1:0]    slice,
   input  logic             key_bit,
   output logic             match,
   output logic             sleep
);

   logic [WIDTH-1:0] one_q;
   logic [WIDTH-1:0] zero_q;
   logic             acc_q;
   logic             active;
   logic             miss;

   // Stored symbols; reset leaves every position as don't-care.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         one_q  <= '0;
         zero_q <= '0;
      end else if (wr_sel) begin
         one_q  <= wr_one;
         zero_q <= wr_zero;
      end
   end

   assign active = cmp_en & ~sleep;
   assign miss   = active & sym_miss(one_q[slice], zero_q[slice], key_bit);

   // Running match flag: set by init, cleared by the first mismatch.
   always_ff @(posedge clk) begin
      if (!rst_n)      acc_q <= 1'b1;
      else if (init)   acc_q <= 1'b1;
      else if (miss)   acc_q <= 1'b0;
   end

   generate
      if (SLEEP_REG) begin : g_sleep_reg
         logic sleep_q;
         always_ff @(posedge clk) begin
            if (!rst_n)      sleep_q <= 1'b0;
            else if (init)   sleep_q <= 1'b0;
            else if (miss)   sleep_q <= 1'b1;
         end
         assign sleep = sleep_q;
      end else begin : g_sleep_derived
         assign sleep = ~acc_q;
      end
   endgenerate

   assign match = acc_q;

endmodule

// File: rtl/serial_tcam_popcnt.sv
module serial_tcam_popcnt #(
   parameter int N  = 32,
   parameter int CW = 6
) (
   input  logic [N-1:0]  vec,
   output logic [CW-1:0] cnt
);

   always_comb begin
      cnt = '0;
      for (int i = 0; i < N; i++) begin
         cnt = cnt + CW'(vec[i]);
      end
   end

endmodule

// File: rtl/serial_tcam.sv
module serial_tcam import serial_tcam_pkg::*; #(
   parameter int  WIDTH     = 16,
   parameter int  DEPTH     = 32,
   parameter bit  SLEEP_REG = 1'b1,
   localparam int AW        = idx_w(DEPTH),
   localparam int SW        = idx_w(WIDTH),
   localparam int CW        = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [WIDTH-1:0] wr_one,
   input  logic [WIDTH-1:0] wr_zero,
   input  logic             srch_start,
   input  logic             key_bit,
   output logic [DEPTH-1:0] match_vec,
   output logic             srch_done,
   output logic [CW-1:0]    awake_cnt
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("serial_tcam: WIDTH must be at least 1");
      end
      if (DEPTH < 1) begin : g_bad_depth
         $error("serial_tcam: DEPTH must be at least 1");
      end
   endgenerate

   logic          busy;
   logic [SW-1:0] slice;
   logic [DEPTH-1:0] sleep_vec;
   logic [DEPTH-1:0] awake_vec;

   serial_tcam_seq #(.WIDTH(WIDTH), .SW(SW)) seq_i (
      .clk   (clk),
      .rst_n (rst_n),
      .start (srch_start),
      .busy  (busy),
      .slice (slice),
      .done  (srch_done)
   );

   generate
      for (genvar w = 0; w < DEPTH; w++) begin : g_word
         logic sel;
         assign sel = wr_en & ~busy & (wr_addr == AW'(w));
         serial_tcam_word #(.WIDTH(WIDTH), .SW(SW), .SLEEP_REG(SLEEP_REG)) word_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_sel  (sel),
            .wr_one  (wr_one),
            .wr_zero (wr_zero),
            .init    (srch_start),
            .cmp_en  (busy),
            .slice   (slice),
            .key_bit (key_bit),
            .match   (match_vec[w]),
            .sleep   (sleep_vec[w])
         );
      end
   endgenerate

   assign awake_vec = ~sleep_vec;

   serial_tcam_popcnt #(.N(DEPTH), .CW(CW)) pop_i (
      .vec (awake_vec),
      .cnt (awake_cnt)
   );

endmodule

// File: rtl/serial_tcam_chk.sv
module serial_tcam_chk #(
   parameter int WIDTH = 16,
   parameter int DEPTH = 32,
   parameter int CW    = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             srch_start,
   input logic             busy,
   input logic [DEPTH-1:0] match_vec,
   input logic             srch_done,
   input logic [CW-1:0]    awake_cnt
);

   localparam int EW = $clog2(WIDTH + 2) + 1;

   // Edges since the last start, saturating just past the last position.
   logic [EW-1:0] ecnt;
   always_ff @(posedge clk) begin
      if (!rst_n)                         ecnt <= '0;
      else if (srch_start)                ecnt <= '0;
      else if (ecnt != EW'(WIDTH + 1))    ecnt <= ecnt + 1'b1;
   end

   // R3
   assert_init_all_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
      srch_start |=> ((&match_vec) && (awake_cnt == CW'(DEPTH))));

   // R5
   assert_match_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !srch_start |=> ((match_vec & ~$past(match_vec)) == '0));

   // R6
   assert_awake_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      32'(awake_cnt) == $countones(match_vec));

   // R6
   assert_awake_no_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !srch_start) |=> (awake_cnt <= $past(awake_cnt)));

   // R8
   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !srch_start) |=> $stable(match_vec));

   // R7
   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      srch_done |=> !srch_done);

   // R7
   assert_done_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      srch_done |-> (ecnt == EW'(WIDTH)));

endmodule

bind serial_tcam serial_tcam_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .CW(CW)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .srch_start (srch_start),
   .busy       (busy),
   .match_vec  (match_vec),
   .srch_done  (srch_done),
   .awake_cnt  (awake_cnt)
);

// File: tb/serial_tcam_tb_top.sv
`timescale 1ns/1ps
module serial_tcam_tb_top;

   localparam int W  = 8;
   localparam int D  = 9;
   localparam int AW = 4;
   localparam int CW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [W-1:0]  wr_one = '0;
   logic [W-1:0]  wr_zero = '0;
   logic          srch_start = 1'b0;
   logic          key_bit = 1'b0;
   logic [D-1:0]  match_vec;
   logic          srch_done;
   logic [CW-1:0] awake_cnt;

   always #10 clk = ~clk;

   serial_tcam #(.WIDTH(W), .DEPTH(D)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_one(wr_one), .wr_zero(wr_zero), .srch_start(srch_start),
      .key_bit(key_bit), .match_vec(match_vec), .srch_done(srch_done),
      .awake_cnt(awake_cnt)
   );

   int checks = 0;
   int failures = 0;

   typedef struct {
      logic [D-1:0] match;
      int           awake;
      string        tag;
   } exp_t;
   exp_t sb_q[$];

   logic [W-1:0] m_one [D];
   logic [W-1:0] m_zero[D];

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [D-1:0] model_match(input logic [W-1:0] key, input logic [W-1:0] mask);
      logic [D-1:0] r;
      for (int d = 0; d < D; d++) begin
         r[d] = ((((m_one[d] & ~key) | (m_zero[d] & key)) & mask) == '0);
      end
      return r;
   endfunction

   task automatic write_word(input int a, input logic [W-1:0] one_r, input logic [W-1:0] zero_r);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_one = one_r; wr_zero = zero_r;
      @(negedge clk);
      wr_en = 1'b0;
      m_one[a] = one_r; m_zero[a] = zero_r;
   endtask

   // Starts a key and drives only n positions, leaving it unfinished.
   task automatic partial_search(input logic [W-1:0] key, input int n);
      @(negedge clk); srch_start = 1'b1;
      @(negedge clk); srch_start = 1'b0;
      for (int j = 0; j < n; j++) begin
         key_bit = key[j];
         @(negedge clk);
      end
   endtask

   task automatic do_search(input logic [W-1:0] key, input bit wr_mid, input string tag);
      exp_t e;
      int   prev;
      e.match = model_match(key, '1);
      e.awake = $countones(e.match);
      e.tag   = tag;
      sb_q.push_back(e);
      @(negedge clk); srch_start = 1'b1;
      @(negedge clk); srch_start = 1'b0;
      chk(&match_vec, "R3 init match", 32'(match_vec), 32'((1 << D) - 1));
      chk(awake_cnt == CW'(D), "R3 init awake", 32'(awake_cnt), 32'(D));
      prev = D;
      for (int j = 0; j < W; j++) begin
         logic [D-1:0] pm;
         key_bit = key[j];
         if (wr_mid && j == 2) begin
            wr_en = 1'b1; wr_addr = AW'(7); wr_one = '1; wr_zero = '0;
         end
         @(negedge clk);
         wr_en = 1'b0;
         pm = model_match(key, W'((1 << (j + 1)) - 1));
         chk(match_vec == pm, "R4 R5 prefix match", 32'(match_vec), 32'(pm));
         chk(int'(awake_cnt) <= prev, "R6 awake no rise", 32'(awake_cnt), 32'(prev));
         prev = int'(awake_cnt);
         chk(srch_done == (j == W - 1), "R7 done slot", 32'(srch_done), 32'(j == W - 1));
      end
      @(negedge clk);
      chk(!srch_done, "R7 done one cycle", 32'(srch_done), 32'd0);
   endtask

   // Scoreboard monitor: compares each finished key against its expectation.
   always @(negedge clk) begin
      if (rst_n && srch_done) begin
         if (sb_q.size() == 0) begin
            chk(1'b0, "R7 unexpected done", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            chk(match_vec == e.match, {e.tag, " match"}, 32'(match_vec), 32'(e.match));
            chk(int'(awake_cnt) == e.awake, "R6 final awake", 32'(awake_cnt), 32'(e.awake));
         end
      end
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int d = 0; d < D; d++) begin m_one[d] = '0; m_zero[d] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2: reset state
      chk(&match_vec, "R2 reset match", 32'(match_vec), 32'((1 << D) - 1));
      chk(awake_cnt == CW'(D), "R2 reset awake", 32'(awake_cnt), 32'(D));
      chk(!srch_done, "R2 reset done", 32'(srch_done), 32'd0);
      do_search(8'h6B, 1'b0, "R2 all dont-care");

      // R1: load a spread of symbol patterns
      write_word(0, 8'hFF, 8'h00);
      write_word(1, 8'h00, 8'hFF);
      write_word(2, 8'h01, 8'h00);
      write_word(3, 8'h00, 8'h80);
      write_word(4, 8'hA5, 8'h5A);
      write_word(5, 8'hA0, 8'h50);
      write_word(6, 8'h08, 8'h08);
      write_word(7, 8'h00, 8'h00);
      write_word(8, 8'h3C, 8'hC3);

      do_search(8'hFF, 1'b0, "R1 key ff");
      do_search(8'h00, 1'b0, "R1 key 00");
      do_search(8'hA5, 1'b0, "R1 key a5");
      do_search(8'h3C, 1'b0, "R1 key 3c");
      do_search(8'hA9, 1'b0, "R1 key a9");
      do_search(8'h01, 1'b0, "R1 key 01");

      // R3: restart while an earlier key is half done
      partial_search(8'h55, 3);
      do_search(8'h7F, 1'b0, "R3 restart");

      // R8: write to word 7 during a key must not land
      do_search(8'h00, 1'b1, "R8 write during key");
      do_search(8'h00, 1'b0, "R8 after ignored write");
      chk(match_vec[7], "R8 word 7 unchanged", 32'(match_vec[7]), 32'd1);

      repeat (3) @(negedge clk);
      chk(sb_q.size() == 0, "R7 all keys done", 32'(sb_q.size()), 32'd0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule